// File: doc/BRIEF.md
# Three-Station Hit Triplet Finder

This block searches one beam crossing's pixel hits for track segments that cross three adjacent detector stations, called here the upstream station (N-1), the middle station (N) and the downstream station (N+1). Each station contributes two planes: one measuring the bend coordinate and one measuring the non-bend coordinate. Before a search, the hits of one crossing are written into six per-plane hit stores as signed coordinates. Each accepted write also records the crossing tag on the load port.

A `start` pulse runs an exhaustive, fixed-order search. Every upstream bend hit that passes the region cut is paired with every middle bend hit. The pair is extrapolated linearly to the downstream station, and the pair is dropped if the extrapolation lands inside the beam hole. Every downstream bend hit inside the track window is then confirmed in the three non-bend planes. Each fully confirmed triplet leaves on a valid/ready stream as a record holding the crossing tag and three bend-hit indices. A `done` level reports that every pair has been tried. New hits are accepted only while the block is idle.

A phase input selects one of two searches. The inner search seeds on hits near the beam axis, for segments that start a track. The outer search seeds on hits far from the axis, for segments near the detector boundary.

Top module: `trip_finder`

## Requirements
- R1: After reset `busy`, `done` and `seg_valid` are low and all six hit stores are empty.
- R2: A load with `ld_valid` high while `busy` is low appends `ld_coord` to the plane coded by `ld_plane` and captures `ld_xing`. The plane codes are: 0 bend N-1, 1 bend N, 2 bend N+1, 3 non-bend N-1, 4 non-bend N, 5 non-bend N+1. Codes 6 and 7 store nothing. Writes to a plane that already holds DEPTH hits are dropped. While `busy` is high, loads and `clear` have no effect. `clear` empties every plane and lowers `done`.
- R3: With `phase_outer` low (latched at start), an upstream bend hit c0 seeds only if |c0| <= `region_lim`. With it high, c0 seeds only if |c0| > `region_lim`.
- R4: The downstream projection is p = 2*c1 - c0, where c1 is the middle bend hit. A downstream bend hit c2 matches if |c2 - p| <= `win_trk`.
- R5: A seed pair with |p| < `hole_lim` is rejected, and no record is produced for it.
- R6: A candidate is confirmed only if each non-bend plane s (s = N-1, N, N+1) holds a hit h with |h - cs| <= the window for that plane. Here cs is the candidate's bend coordinate at that station (c0, c1 or c2).
- R7: Records come out in ascending order of upstream index, then middle index, then downstream index. Each confirmed triplet appears exactly once.
- R8: A record carries the crossing tag of the last accepted load and the indices, in load order, of the three bend hits.
- R9: While `seg_valid` is high and `seg_ready` is low, `seg_valid` and every record field hold their values.
- R10: `done` rises after the last pair has been tried. It is never high together with `busy`, and it stays high until the next `start` or `clear`. A start with an empty upstream or middle bend plane finishes immediately with no records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Hit write strobe |
| ld_plane | input | 3 | Target plane code |
| ld_coord | input | CW | Signed hit coordinate |
| ld_xing | input | XW | Crossing tag for the hit |
| clear | input | 1 | Empty all planes (ignored while busy) |
| start | input | 1 | Begin a search |
| phase_outer | input | 1 | 0 inner search, 1 outer search |
| region_lim | input | CW | Seed region radius |
| hole_lim | input | CW | Beam hole radius |
| win_trk | input | WW | Downstream bend window |
| win_nb0 | input | WW | Non-bend window, station N-1 |
| win_nb1 | input | WW | Non-bend window, station N |
| win_nb2 | input | WW | Non-bend window, station N+1 |
| busy | output | 1 | Search in progress |
| done | output | 1 | All seed pairs tried |
| seg_valid | output | 1 | Record available |
| seg_ready | input | 1 | Consumer accepts record |
| seg_xing | output | XW | Record crossing tag |
| seg_idx0 | output | $clog2(DEPTH) | Upstream bend hit index |
| seg_idx1 | output | $clog2(DEPTH) | Middle bend hit index |
| seg_idx2 | output | $clog2(DEPTH) | Downstream bend hit index |

## Verification
The search is driven with randomly placed straight tracks plus scattered noise hits. Every produced record is compared, in order, against a list computed arithmetically from the loaded hits. Runs with the inner and the outer seed cut on identical hits separate the region test from the rest. Zero-width windows separate exact extrapolation from the tolerance compare, and a wide beam hole shows whether rejection happens before the downstream scan.

Three patterns check the edges of the storage and control rules. An over-full upstream plane shows whether writes past the store depth are dropped. An empty downstream plane shows the no-match termination. Loads and clears injected mid-search, followed by a repeat search, show that the stores are frozen while busy.

// File: rtl/trip_pkg.sv
package trip_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEED,
      ST_TRK,
      ST_NB,
      ST_EMIT
   } trip_state_t;

   localparam int NPLANE = 6;
   localparam int PL_B0  = 0;
   localparam int PL_B1  = 1;
   localparam int PL_B2  = 2;
   localparam int PL_U0  = 3;
endpackage

// File: rtl/trip_hit_store.sv
module trip_hit_store #(
   parameter int CW    = 10,
   parameter int DEPTH = 64,
   parameter int IW    = $clog2(DEPTH),
   parameter int CNTW  = $clog2(DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 wr,
   input  logic signed [CW-1:0] wr_data,
   input  logic [IW-1:0]        rd_idx,
   output logic signed [CW-1:0] rd_data,
   output logic [CNTW-1:0]      cnt
);
   logic signed [CW-1:0] mem [DEPTH];
   logic                 room;

   assign room    = cnt < CNTW'(DEPTH);
   assign rd_data = mem[rd_idx];

   always_ff @(posedge clk) begin
      if (wr && room && !clr) mem[cnt[IW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt <= '0;
      else if (clr)         cnt <= '0;
      else if (wr && room)  cnt <= cnt + CNTW'(1);
   end

   // a full plane keeps its count when written again
   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNTW'(DEPTH) && wr && !clr) |=> cnt == CNTW'(DEPTH));
endmodule

// File: rtl/trip_proj.sv
module trip_proj #(
   parameter int CW = 10,
   parameter int PW = CW + 2
) (
   input  logic signed [CW-1:0] c0,
   input  logic signed [CW-1:0] c1,
   input  logic                 phase_outer,
   input  logic [CW-1:0]        region_lim,
   input  logic [CW-1:0]        hole_lim,
   output logic signed [PW-1:0] proj,
   output logic                 seed_ok
);
   logic signed [PW-1:0] e0, e1;
   logic [CW:0]          a0;
   logic [PW-1:0]        ap;
   logic                 region_ok, in_hole;

   assign e0   = {{2{c0[CW-1]}}, c0};
   assign e1   = {{2{c1[CW-1]}}, c1};
   assign proj = (e1 <<< 1) - e0;

   always_comb begin
      a0 = c0[CW-1] ? (CW+1)'(-e0) : (CW+1)'(e0);
      ap = proj[PW-1] ? PW'(-proj) : PW'(proj);
      region_ok = phase_outer ? (a0 >  {1'b0, region_lim})
                              : (a0 <= {1'b0, region_lim});
      in_hole = ap < {2'b00, hole_lim};
      seed_ok = region_ok && !in_hole;
   end
endmodule

// File: rtl/trip_win_cmp.sv
module trip_win_cmp #(
   parameter int W  = 12,
   parameter int WW = 6
) (
   input  logic signed [W-1:0] a,
   input  logic signed [W-1:0] b,
   input  logic [WW-1:0]       win,
   output logic                hit
);
   logic signed [W:0] d;
   logic [W:0]        ad;

   always_comb begin
      d   = {a[W-1], a} - {b[W-1], b};
      ad  = d[W] ? (W+1)'(-d) : (W+1)'(d);
      hit = ad <= {{(W+1-WW){1'b0}}, win};
   end
endmodule

// File: rtl/trip_seq.sv
module trip_seq
   import trip_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int IW    = $clog2(DEPTH),
   parameter int CNTW  = $clog2(DEPTH + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic                        clear,
   input  logic                        phase_in,
   input  logic [NPLANE-1:0][CNTW-1:0] cnts,
   input  logic                        seed_ok,
   input  logic                        trk_ok,
   input  logic                        nb_ok,
   input  logic                        seg_ready,
   output logic [IW-1:0]               i_q,
   output logic [IW-1:0]               j_q,
   output logic [IW-1:0]               k_q,
   output logic [IW-1:0]               m_q,
   output logic [1:0]                  pl_q,
   output logic                        phase_q,
   output logic                        busy,
   output logic                        done,
   output logic                        seg_valid
);
   trip_state_t st, st_n;
   logic [IW-1:0] i_n, j_n, k_n, m_n;
   logic [1:0]    pl_n;
   logic          busy_n, done_n, phase_n;
   logic          adv_k, adv_pair;
   logic          last_i, last_j, last_k, last_m;
   logic [CNTW-1:0] cnt_nb, cnt_nb_next;

   always_comb begin
      case (pl_q)
         2'd0:    begin cnt_nb = cnts[PL_U0];     cnt_nb_next = cnts[PL_U0 + 1]; end
         2'd1:    begin cnt_nb = cnts[PL_U0 + 1]; cnt_nb_next = cnts[PL_U0 + 2]; end
         default: begin cnt_nb = cnts[PL_U0 + 2]; cnt_nb_next = '0;             end
      endcase
      last_i = (CNTW'(i_q) + CNTW'(1)) >= cnts[PL_B0];
      last_j = (CNTW'(j_q) + CNTW'(1)) >= cnts[PL_B1];
      last_k = (CNTW'(k_q) + CNTW'(1)) >= cnts[PL_B2];
      last_m = (CNTW'(m_q) + CNTW'(1)) >= cnt_nb;
   end

   always_comb begin
      st_n     = st;
      i_n      = i_q;
      j_n      = j_q;
      k_n      = k_q;
      m_n      = m_q;
      pl_n     = pl_q;
      busy_n   = busy;
      done_n   = done;
      phase_n  = phase_q;
      adv_k    = 1'b0;
      adv_pair = 1'b0;
      case (st)
         ST_IDLE: begin
            if (start && !clear) begin
               phase_n = phase_in;
               i_n     = '0;
               j_n     = '0;
               if (cnts[PL_B0] == '0 || cnts[PL_B1] == '0) begin
                  done_n = 1'b1;
               end else begin
                  done_n = 1'b0;
                  busy_n = 1'b1;
                  st_n   = ST_SEED;
               end
            end else if (clear) begin
               done_n = 1'b0;
            end
         end
         ST_SEED: begin
            if (seed_ok && cnts[PL_B2] != '0) begin
               k_n  = '0;
               st_n = ST_TRK;
            end else begin
               adv_pair = 1'b1;
            end
         end
         ST_TRK: begin
            if (trk_ok && cnts[PL_U0] != '0) begin
               pl_n = 2'd0;
               m_n  = '0;
               st_n = ST_NB;
            end else begin
               adv_k = 1'b1;
            end
         end
         ST_NB: begin
            if (nb_ok) begin
               if (pl_q == 2'd2) begin
                  st_n = ST_EMIT;
               end else if (cnt_nb_next == '0) begin
                  adv_k = 1'b1;
               end else begin
                  pl_n = pl_q + 2'd1;
                  m_n  = '0;
               end
            end else if (!last_m) begin
               m_n = m_q + IW'(1);
            end else begin
               adv_k = 1'b1;
            end
         end
         ST_EMIT: begin
            if (seg_ready) adv_k = 1'b1;
         end
         default: st_n = ST_IDLE;
      endcase

      if (adv_k) begin
         if (!last_k) begin
            k_n  = k_q + IW'(1);
            st_n = ST_TRK;
         end else begin
            adv_pair = 1'b1;
         end
      end
      if (adv_pair) begin
         if (!last_j) begin
            j_n  = j_q + IW'(1);
            st_n = ST_SEED;
         end else if (!last_i) begin
            i_n  = i_q + IW'(1);
            j_n  = '0;
            st_n = ST_SEED;
         end else begin
            st_n   = ST_IDLE;
            busy_n = 1'b0;
            done_n = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         i_q     <= '0;
         j_q     <= '0;
         k_q     <= '0;
         m_q     <= '0;
         pl_q    <= '0;
         busy    <= 1'b0;
         done    <= 1'b0;
         phase_q <= 1'b0;
      end else begin
         st      <= st_n;
         i_q     <= i_n;
         j_q     <= j_n;
         k_q     <= k_n;
         m_q     <= m_n;
         pl_q    <= pl_n;
         busy    <= busy_n;
         done    <= done_n;
         phase_q <= phase_n;
      end
   end

   assign seg_valid = (st == ST_EMIT);

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid && !seg_ready) |=> (seg_valid && $stable(i_q) && $stable(j_q) && $stable(k_q)));
   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   assert_emit_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid |-> busy);
   assert_idx_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid |-> (CNTW'(i_q) < cnts[PL_B0] && CNTW'(j_q) < cnts[PL_B1] && CNTW'(k_q) < cnts[PL_B2]));
endmodule

// File: rtl/trip_finder.sv
module trip_finder
   import trip_pkg::*;
#(
   parameter int CW    = 10,
   parameter int DEPTH = 64,
   parameter int XW    = 8,
   parameter int WW    = 6
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ld_valid,
   input  logic [2:0]                 ld_plane,
   input  logic [CW-1:0]              ld_coord,
   input  logic [XW-1:0]              ld_xing,
   input  logic                       clear,
   input  logic                       start,
   input  logic                       phase_outer,
   input  logic [CW-1:0]              region_lim,
   input  logic [CW-1:0]              hole_lim,
   input  logic [WW-1:0]              win_trk,
   input  logic [WW-1:0]              win_nb0,
   input  logic [WW-1:0]              win_nb1,
   input  logic [WW-1:0]              win_nb2,
   output logic                       busy,
   output logic                       done,
   output logic                       seg_valid,
   input  logic                       seg_ready,
   output logic [XW-1:0]              seg_xing,
   output logic [$clog2(DEPTH)-1:0]   seg_idx0,
   output logic [$clog2(DEPTH)-1:0]   seg_idx1,
   output logic [$clog2(DEPTH)-1:0]   seg_idx2
);
   localparam int IW   = $clog2(DEPTH);
   localparam int CNTW = $clog2(DEPTH + 1);
   localparam int PW   = CW + 2;

   if (DEPTH < 2)      begin : g_bad_depth $error("DEPTH must be at least 2"); end
   if (CW < 4)         begin : g_bad_cw    $error("CW must be at least 4"); end
   if (WW >= PW + 1)   begin : g_bad_ww    $error("WW must be narrower than the projection"); end

   logic [NPLANE-1:0][CNTW-1:0] cnts;
   logic signed [CW-1:0]        rd [NPLANE];
   logic [IW-1:0]               i_q, j_q, k_q, m_q;
   logic [1:0]                  pl_q;
   logic                        phase_q;
   logic signed [PW-1:0]        proj;
   logic                        seed_ok, trk_ok, nb_ok;
   logic signed [CW-1:0]        nb_hit, nb_tgt;
   logic [WW-1:0]               nb_win;
   logic [XW-1:0]               xing_q;
   logic                        ld_ok, clr_ok;

   assign ld_ok  = ld_valid && !busy;
   assign clr_ok = clear && !busy;

   for (genvar g = 0; g < NPLANE; g++) begin : g_plane
      logic [IW-1:0] rsel;
      if (g == PL_B0)      begin : g_r0 assign rsel = i_q; end
      else if (g == PL_B1) begin : g_r1 assign rsel = j_q; end
      else if (g == PL_B2) begin : g_r2 assign rsel = k_q; end
      else                 begin : g_rn assign rsel = m_q; end

      trip_hit_store #(.CW(CW), .DEPTH(DEPTH), .IW(IW), .CNTW(CNTW)) u_store (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (clr_ok),
         .wr      (ld_ok && ld_plane == 3'(g)),
         .wr_data (ld_coord),
         .rd_idx  (rsel),
         .rd_data (rd[g]),
         .cnt     (cnts[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     xing_q <= '0;
      else if (ld_ok) xing_q <= ld_xing;
   end

   trip_proj #(.CW(CW), .PW(PW)) u_proj (
      .c0          (rd[PL_B0]),
      .c1          (rd[PL_B1]),
      .phase_outer (phase_q),
      .region_lim  (region_lim),
      .hole_lim    (hole_lim),
      .proj        (proj),
      .seed_ok     (seed_ok)
   );

   trip_win_cmp #(.W(PW), .WW(WW)) u_trk_cmp (
      .a   ({{2{rd[PL_B2][CW-1]}}, rd[PL_B2]}),
      .b   (proj),
      .win (win_trk),
      .hit (trk_ok)
   );

   always_comb begin
      case (pl_q)
         2'd0:    begin nb_hit = rd[PL_U0];     nb_tgt = rd[PL_B0]; nb_win = win_nb0; end
         2'd1:    begin nb_hit = rd[PL_U0 + 1]; nb_tgt = rd[PL_B1]; nb_win = win_nb1; end
         default: begin nb_hit = rd[PL_U0 + 2]; nb_tgt = rd[PL_B2]; nb_win = win_nb2; end
      endcase
   end

   trip_win_cmp #(.W(PW), .WW(WW)) u_nb_cmp (
      .a   ({{2{nb_hit[CW-1]}}, nb_hit}),
      .b   ({{2{nb_tgt[CW-1]}}, nb_tgt}),
      .win (nb_win),
      .hit (nb_ok)
   );

   trip_seq #(.DEPTH(DEPTH), .IW(IW), .CNTW(CNTW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .clear     (clear),
      .phase_in  (phase_outer),
      .cnts      (cnts),
      .seed_ok   (seed_ok),
      .trk_ok    (trk_ok),
      .nb_ok     (nb_ok),
      .seg_ready (seg_ready),
      .i_q       (i_q),
      .j_q       (j_q),
      .k_q       (k_q),
      .m_q       (m_q),
      .pl_q      (pl_q),
      .phase_q   (phase_q),
      .busy      (busy),
      .done      (done),
      .seg_valid (seg_valid)
   );

   assign seg_xing = xing_q;
   assign seg_idx0 = i_q;
   assign seg_idx1 = j_q;
   assign seg_idx2 = k_q;

   assert_frozen_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (ld_valid || clear)) |=> ($stable(cnts) && $stable(xing_q)));
   assert_emit_seed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid |-> seed_ok);
   assert_emit_track_R4: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid |-> trk_ok);
endmodule

// File: tb/trip_finder_test.sv
module trip_finder_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ld_valid = 1'b0;
   logic [2:0] ld_plane = '0;
   logic [9:0] ld_coord = '0;
   logic [7:0] ld_xing = '0;
   logic clear = 1'b0, start = 1'b0, phase_outer = 1'b0;
   logic [9:0] region_lim = '0, hole_lim = '0;
   logic [5:0] win_trk = '0, win_nb0 = '0, win_nb1 = '0, win_nb2 = '0;
   logic busy, done, seg_valid;
   logic seg_ready = 1'b0;
   logic [7:0] seg_xing;
   logic [5:0] seg_idx0, seg_idx1, seg_idx2;

   int checks = 0, fails = 0;
   bit finished = 0;
   int hc [6][80];
   int hn [6];
   int cur_xing = 0;
   int ex_rec [4096];
   int nex = 0;

   always #10 clk = ~clk;

   trip_finder uut (
      .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_plane(ld_plane),
      .ld_coord(ld_coord), .ld_xing(ld_xing), .clear(clear), .start(start),
      .phase_outer(phase_outer), .region_lim(region_lim), .hole_lim(hole_lim),
      .win_trk(win_trk), .win_nb0(win_nb0), .win_nb1(win_nb1), .win_nb2(win_nb2),
      .busy(busy), .done(done), .seg_valid(seg_valid), .seg_ready(seg_ready),
      .seg_xing(seg_xing), .seg_idx0(seg_idx0), .seg_idx1(seg_idx1), .seg_idx2(seg_idx2)
   );

   function automatic int iabs(int v);
      return (v < 0) ? -v : v;
   endfunction

   function automatic int pack_rec(int x, int a, int b, int c);
      return (x << 18) | (a << 12) | (b << 6) | c;
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_load(int pl, int c, int x);
      @(negedge clk);
      ld_valid = 1'b1; ld_plane = 3'(pl); ld_coord = 10'(c); ld_xing = 8'(x);
      @(negedge clk);
      ld_valid = 1'b0;
      cur_xing = x;
      if (pl < 6 && hn[pl] < 64) begin
         hc[pl][hn[pl]] = c;
         hn[pl]++;
      end
   endtask

   task automatic do_clear();
      @(negedge clk); clear = 1'b1;
      @(negedge clk); clear = 1'b0;
      for (int p = 0; p < 6; p++) hn[p] = 0;
   endtask

   // reference search: R3 region, R4 projection, R5 hole, R6 non-bend, R7 order
   task automatic build_exp();
      bit ok;
      int c0, c1, c2, p;
      nex = 0;
      for (int i = 0; i < hn[0]; i++) begin
         c0 = hc[0][i];
         ok = phase_outer ? (iabs(c0) > int'(region_lim)) : (iabs(c0) <= int'(region_lim));
         if (!ok) continue;
         for (int j = 0; j < hn[1]; j++) begin
            c1 = hc[1][j];
            p = 2 * c1 - c0;
            if (iabs(p) < int'(hole_lim)) continue;
            for (int k = 0; k < hn[2]; k++) begin
               bit f0, f1, f2;
               c2 = hc[2][k];
               if (iabs(c2 - p) > int'(win_trk)) continue;
               f0 = 0; f1 = 0; f2 = 0;
               for (int m = 0; m < hn[3]; m++) if (iabs(hc[3][m] - c0) <= int'(win_nb0)) f0 = 1;
               for (int m = 0; m < hn[4]; m++) if (iabs(hc[4][m] - c1) <= int'(win_nb1)) f1 = 1;
               for (int m = 0; m < hn[5]; m++) if (iabs(hc[5][m] - c2) <= int'(win_nb2)) f2 = 1;
               if (f0 && f1 && f2) begin
                  ex_rec[nex] = pack_rec(cur_xing, i, j, k);
                  nex++;
               end
            end
         end
      end
   endtask

   task automatic run_search(bit poke, string tag);
      int got, cyc, act, held;
      bit pend;
      build_exp();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      got = 0; cyc = 0; pend = 0; held = 0;
      while (1) begin
         @(negedge clk);
         cyc++;
         if (poke) begin
            // R2: loads and clear during a search must leave the stores untouched
            ld_valid = (cyc == 3);
            ld_plane = 3'd0; ld_coord = 10'd0; ld_xing = 8'hEE;
            clear = (cyc == 5);
         end
         act = pack_rec(int'(seg_xing), int'(seg_idx0), int'(seg_idx1), int'(seg_idx2));
         if (seg_valid) begin
            if (pend) chk(act == held, "R9", "record changed under backpressure", act, held);
            if ($urandom_range(3) != 0) begin
               seg_ready = 1'b1;
               pend = 0;
               if (got < nex)
                  chk(act == ex_rec[got], "R7/R8", {tag, " record"}, act, ex_rec[got]);
               else
                  chk(0, "R7", {tag, " extra record"}, got + 1, nex);
               got++;
            end else begin
               seg_ready = 1'b0;
               pend = 1; held = act;
            end
         end else begin
            seg_ready = 1'b0;
            if (done && cyc > 6) break;
            if (done && !poke) break;
         end
      end
      ld_valid = 1'b0; clear = 1'b0; seg_ready = 1'b0;
      chk(got == nex, "R7", {tag, " record count"}, got, nex);
      chk(done && !busy, "R10", {tag, " done after search"}, {busy, done}, 1);
   endtask

   task automatic gen_hits(int ntrk, int njunk);
      int a, s, n;
      do_clear();
      for (int t = 0; t < ntrk; t++) begin
         a = int'($urandom_range(300)) - 150;
         s = int'($urandom_range(60)) - 30;
         n = int'($urandom_range(6)) - 3;
         do_load(0, a, 20 + t);
         do_load(1, a + s, 20 + t);
         do_load(2, a + 2 * s + n, 20 + t);
         do_load(3, a + int'($urandom_range(6)) - 3, 20 + t);
         do_load(4, a + s + int'($urandom_range(6)) - 3, 20 + t);
         do_load(5, a + 2 * s + n + int'($urandom_range(6)) - 3, 20 + t);
      end
      for (int q = 0; q < njunk; q++)
         for (int p = 0; p < 6; p++)
            do_load(p, int'($urandom_range(400)) - 200, 60 + q);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL R10 watchdog expired: actual busy=%0d expected search end", busy);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      for (int p = 0; p < 6; p++) hn[p] = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!busy && !done && !seg_valid, "R1", "outputs after reset", {busy, done, seg_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      region_lim = 10'd60; hole_lim = 10'd8;
      win_trk = 6'd4; win_nb0 = 6'd3; win_nb1 = 6'd3; win_nb2 = 6'd3;
      // R1/R10: empty stores finish at once with no records
      run_search(0, "empty");
      // R2: code 7 stores nothing
      do_load(7, 5, 3);
      run_search(0, "unused code");

      // R3..R7 sweeps on random tracks, both phases, several window settings
      for (int r = 0; r < 8; r++) begin
         gen_hits(4, 2);
         case (r % 4)
            0: begin win_trk = 6'd4; win_nb0 = 6'd3; win_nb1 = 6'd3; win_nb2 = 6'd3; hole_lim = 10'd8; end
            1: begin win_trk = 6'd0; win_nb0 = 6'd0; win_nb1 = 6'd0; win_nb2 = 6'd0; hole_lim = 10'd0; end
            2: begin win_trk = 6'd63; win_nb0 = 6'd20; win_nb1 = 6'd63; win_nb2 = 6'd10; hole_lim = 10'd8; end
            default: begin win_trk = 6'd8; win_nb0 = 6'd5; win_nb1 = 6'd5; win_nb2 = 6'd5; hole_lim = 10'd120; end
         endcase
         region_lim = 10'(40 + 20 * r);
         phase_outer = 1'b0; run_search(0, "R3 inner sweep");
         phase_outer = 1'b1; run_search(0, "R3 outer sweep");
      end

      // R5: exact hole boundary, p = 10 rejected at hole 11, kept at hole 10
      do_clear();
      win_trk = 6'd0; win_nb0 = 6'd0; win_nb1 = 6'd0; win_nb2 = 6'd0;
      phase_outer = 1'b0; region_lim = 10'd100;
      do_load(0, 2, 9); do_load(1, 6, 9); do_load(2, 10, 9);
      do_load(3, 2, 9); do_load(4, 6, 9); do_load(5, 10, 9);
      hole_lim = 10'd11; run_search(0, "R5 inside hole");
      hole_lim = 10'd10; run_search(0, "R5 hole edge");
      // R6: non-bend N+1 hit one outside its window
      do_load(5, 14, 9); win_nb2 = 6'd3; hole_lim = 10'd0;
      do_clear();
      do_load(0, 2, 9); do_load(1, 6, 9); do_load(2, 10, 9);
      do_load(3, 2, 9); do_load(4, 6, 9); do_load(5, 14, 9);
      run_search(0, "R6 non-bend miss");
      win_nb2 = 6'd4; run_search(0, "R6 non-bend edge");

      // R10: empty downstream plane
      do_clear();
      do_load(0, 1, 4); do_load(1, 3, 4);
      run_search(0, "R10 empty N+1");

      // R2: overflow of upstream plane
      do_clear();
      hole_lim = 10'd0; win_trk = 6'd63; win_nb0 = 6'd63; win_nb1 = 6'd63; win_nb2 = 6'd63;
      for (int q = 0; q < 70; q++) do_load(0, 0, 5);
      do_load(1, 5, 6); do_load(2, 10, 6);
      do_load(3, 0, 6); do_load(4, 5, 6); do_load(5, 10, 6);
      run_search(0, "R2 overflow");

      // R2: loads and clear while busy, then repeat search
      gen_hits(5, 2);
      win_trk = 6'd8; win_nb0 = 6'd4; win_nb1 = 6'd4; win_nb2 = 6'd4;
      region_lim = 10'd300; phase_outer = 1'b0;
      run_search(1, "R2 busy poke");
      run_search(0, "R2 after poke");

      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule